// File: doc/BRIEF.md
# Two-Level Lookahead Adder

A purely combinational 16-bit binary adder. The operand width is split into four 4-bit slices. Inside each slice, every bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). A flat sum-of-products network then produces every carry of the slice directly from those terms and the slice carry-in, without waiting on the carry below it.

Each slice also reports its own block generate and block propagate. A second network of the same shape combines these four pairs with the adder carry-in, so the carry into every slice is available in parallel. The adder exports the overall generate/propagate pair. A wider adder can therefore place this block under a further lookahead level.

The result settles within the cycle the operands are applied. No ports carry a handshake, and there are no registers in the path.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit 16 of the 17-bit value `op_a + op_b + carry_in`.
- R3: `blk_prop` is 1 exactly when, at every bit position, at least one of `op_a` and `op_b` is 1.
- R4: `blk_gen` is 1 exactly when `op_a + op_b` with no carry-in exceeds 16 bits.
- R5: `carry_out` always equals `blk_gen OR (blk_prop AND carry_in)`, so the block can be cascaded.
- R6: When `op_b` is the bitwise inverse of `op_a`, no bit generates a carry. In that case `carry_out` equals `carry_in`, and `sum` is all ones for carry-in 0 or all zeros for carry-in 1.
- R7: Every internal carry matches the one-bit recurrence: carry into bit i+1 = gen_i OR (prop_i AND carry into bit i).
- R8: With `GROUPS` = 1 (a single 4-bit slice), the same arithmetic of R1 to R5 holds at width 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |
| blk_gen | output | 1 | Whole-block generate, for an outer lookahead level |
| blk_prop | output | 1 | Whole-block propagate, for an outer lookahead level |

## Verification
The bench builds two instances: the default four slices of four bits, and a single 4-bit slice (`GROUPS` = 1).

The single-slice instance is small enough to drive through all 512 combinations of operands and carry-in. This exhaustively covers the within-slice carry network and the second-level network at its smallest size.

The 16-bit instance receives seeded random operands plus directed vectors aimed at the second level:
- full propagate chains with and without carry-in;
- a generate in the lowest slice that must travel through three propagating slices;
- patterns where every bit propagates through OR but none sums to one.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // generate/propagate pair reported by a span of bits
  typedef struct packed {
    logic gen;
    logic prop;
  } gp_pair_t;
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] | b[i];
  end
endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         span_gen,
  output logic         span_prop
);
  // every carry is a flat OR of products; no term reads a lower carry
  always_comb begin
    logic acc;
    logic run;
    carry[0] = cin;
    for (int j = 0; j < N; j++) begin
      acc = 1'b0;
      for (int k = 0; k <= j; k++) begin
        run = gen[k];
        for (int m = k + 1; m <= j; m++) run = run & prop[m];
        acc = acc | run;
      end
      run = cin;
      for (int m = 0; m <= j; m++) run = run & prop[m];
      carry[j+1] = acc | run;
    end
  end

  always_comb begin
    logic acc;
    logic run;
    acc = 1'b0;
    for (int k = 0; k < N; k++) begin
      run = gen[k];
      for (int m = k + 1; m < N; m++) run = run & prop[m];
      acc = acc | run;
    end
    span_gen = acc;
  end

  assign span_prop = &prop;

  // R7: flat expansion agrees with the one-step recurrence at each position
  for (genvar j = 0; j < N; j++) begin : g_chk
    always_comb begin
      // R7
      carry_ripple_chk: assert (carry[j+1] == (gen[j] | (prop[j] & carry[j])))
        else $error("carry %0d breaks recurrence", j + 1);
    end
  end

  // R5: top carry agrees with the span pair computed separately
  always_comb begin
    // R5
    span_pair_chk: assert (carry[N] == (span_gen | (span_prop & cin)))
      else $error("span pair disagrees with top carry");
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output gp_pair_t     gp
);
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W:0]   c;
  logic         sg;
  logic         sp;

  cla_pg_cell #(.W(W)) u_pg (
    .a    (a),
    .b    (b),
    .gen  (bit_gen),
    .prop (bit_prop)
  );

  cla_carry_net #(.N(W)) u_net (
    .gen       (bit_gen),
    .prop      (bit_prop),
    .cin       (cin),
    .carry     (c),
    .span_gen  (sg),
    .span_prop (sp)
  );

  assign sum     = a ^ b ^ c[W-1:0];
  assign gp.gen  = sg;
  assign gp.prop = sp;

  always_comb begin
    // R1
    group_sum_chk: assert ({c[W], sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("slice sum mismatch");
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int GROUP_W = 4,
  parameter int GROUPS  = 4,
  localparam int WIDTH  = GROUP_W * GROUPS
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             blk_gen,
  output logic             blk_prop
);
  gp_pair_t [GROUPS-1:0] grp_gp;
  logic [GROUPS-1:0]     grp_gen;
  logic [GROUPS-1:0]     grp_prop;
  logic [GROUPS:0]       grp_c;

  for (genvar j = 0; j < GROUPS; j++) begin : g_slice
    cla_group #(.W(GROUP_W)) u_grp (
      .a   (op_a[j*GROUP_W +: GROUP_W]),
      .b   (op_b[j*GROUP_W +: GROUP_W]),
      .cin (grp_c[j]),
      .sum (sum[j*GROUP_W +: GROUP_W]),
      .gp  (grp_gp[j])
    );
    assign grp_gen[j]  = grp_gp[j].gen;
    assign grp_prop[j] = grp_gp[j].prop;
  end

  // second level: carries into all slices at once
  cla_carry_net #(.N(GROUPS)) u_top_net (
    .gen       (grp_gen),
    .prop      (grp_prop),
    .cin       (carry_in),
    .carry     (grp_c),
    .span_gen  (blk_gen),
    .span_prop (blk_prop)
  );

  assign carry_out = grp_c[GROUPS];

  always_comb begin
    // R2
    full_add_chk: assert ({carry_out, sum} ==
                          ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("adder result mismatch");
    // R3
    blk_prop_chk: assert (blk_prop == (&(op_a | op_b)))
      else $error("block propagate mismatch");
  end
endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] a16, b16, s16;
  logic        ci16, co16, g16, p16;
  logic [3:0]  a4, b4, s4;
  logic        ci4, co4, g4, p4;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  cla_adder dut (
    .op_a(a16), .op_b(b16), .carry_in(ci16),
    .sum(s16), .carry_out(co16), .blk_gen(g16), .blk_prop(p16)
  );

  cla_adder #(.GROUP_W(4), .GROUPS(1)) dut_one (
    .op_a(a4), .op_b(b4), .carry_in(ci4),
    .sum(s4), .carry_out(co4), .blk_gen(g4), .blk_prop(p4)
  );

  function automatic logic [16:0] ref16(logic [15:0] x, logic [15:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  function automatic logic [4:0] ref4(logic [3:0] x, logic [3:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {4'd0, c};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h ci=%b)", req, got, exp, a16, b16, ci16);
    end
  endtask

  task automatic run16(logic [15:0] x, logic [15:0] y, logic c);
    logic [16:0] r;
    logic [16:0] r0;
    @(posedge clk);
    a16 = x; b16 = y; ci16 = c;
    @(negedge clk);
    r  = ref16(x, y, c);
    r0 = ref16(x, y, 1'b0);
    chk("R1", {16'd0, s16}, {16'd0, r[15:0]});
    chk("R2", {31'd0, co16}, {31'd0, r[16]});
    chk("R3", {31'd0, p16}, {31'd0, &(x | y)});
    chk("R4", {31'd0, g16}, {31'd0, r0[16]});
    chk("R5", {31'd0, co16}, {31'd0, g16 | (p16 & c)});
  endtask

  initial begin
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a4 = '0; b4 = '0; ci4 = 1'b0;
    @(negedge clk);
    // idle state with zero operands
    chk("R1", {16'd0, s16}, 32'd0);
    chk("R2", {31'd0, co16}, 32'd0);

    // R8: exhaustive single slice
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          logic [4:0] r;
          @(posedge clk);
          a4 = x[3:0]; b4 = y[3:0]; ci4 = c[0];
          @(negedge clk);
          r = ref4(x[3:0], y[3:0], c[0]);
          chk("R8", {27'd0, co4, s4}, {27'd0, r});
          chk("R8", {30'd0, g4, p4},
              {30'd0, ref4(x[3:0], y[3:0], 1'b0) >> 4, &(x[3:0] | y[3:0])});
        end

    // R6: full XOR propagate chains, carry must ride through every slice
    for (int c = 0; c < 2; c++) begin
      logic [15:0] x;
      x = 16'hA5C3;
      run16(x, ~x, c[0]);
      chk("R6", {15'd0, co16, s16}, {15'd0, c[0], (c[0] ? 16'h0000 : 16'hFFFF)});
      run16(16'h0000, 16'hFFFF, c[0]);
      chk("R6", {31'd0, co16}, {31'd0, c[0]});
    end
    // low slice generates, upper slices propagate
    run16(16'h0FFF, 16'h0001, 1'b0);
    run16(16'hFFF8, 16'h0008, 1'b0);
    // all bits propagate through OR with no XOR chain
    run16(16'hFFFF, 16'hFFFF, 1'b1);
    run16(16'hFFFF, 16'hFFFF, 1'b0);
    run16(16'h8000, 16'h8000, 1'b0);

    // random vectors (R1 to R5)
    void'($urandom(32'd4217));
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] x, y;
      x = $urandom();
      y = $urandom();
      if (n % 7 == 0) y = ~x;
      run16(x, y, $urandom() % 2 == 1);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule